// File: doc/BRIEF.md
# Keyed Watchdog Timer with Write-Once Mode

This block is a watchdog counter that raises a one-cycle internal reset request when it runs past a selectable terminal count. It advances only on one of two tick enables: a fast system tick or a slow oscillator tick. The count is chosen by an 8-bit mode register, which also selects the tick source and the period, or stops the timer. After reset the timer already runs on the slow tick with its longest period, so firmware that never configures it is still supervised.

Firmware services the timer by writing a fixed key byte to the enable address. Any other byte written there is treated as a runaway and requests a reset. The mode register accepts a single write after reset; a further write is also treated as a runaway, unless the first write stopped the timer. An option strap can pin the timer to the slow tick so that the software cannot switch it away or stop it. Two sticky cause flags record why a request fired. They survive the block's own reset and are cleared only by a power-on reset.

Top module: `keyed_wdt`

## Requirements
- R1: In the mode register, bits 4:3 select the source: 00 is the slow tick, 01 is the system tick, and 1x stops the timer. Bits 2:0 are a code c. The period is 2^(SYS_BASE+c) system ticks or 2^(SLOW_BASE+c) slow ticks (defaults 13 and 11).
- R2: Mode bits 7:5 always read back as 011, whatever value was written to them.
- R3: After rst_n the mode register reads 0x67: the slow tick, code 7. The timer counts and overflows without any write.
- R4: Writing 0xAC to address 1 clears the count and gives no reset request. A full new period follows.
- R5: Writing any value other than 0xAC to address 1 raises the reset request on the next cycle and sets cause_access.
- R6: Address 0 loads the mode register once after rst_n. A later write there raises the reset request and leaves the mode unchanged. If the accepted value had bit 4 set, later writes are ignored with no request.
- R7: While slow_forced is 1, the slow tick drives the timer with the written code, even when the source bits select the system tick or stop.
- R8: While the timer is stopped, no overflow request is raised.
- R9: rst_req is high for exactly one cycle. It follows the edge that counts the 2^e-th selected tick since the last clear. An accepted mode write also clears the count.
- R10: cause_overflow and cause_access are set together with the request they explain. They hold through rst_n and are cleared only by por_n.
- R11: Writes to addresses other than 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low block reset; clears count, lock and mode |
| por_n | input | 1 | Active-low power-on reset; also clears the cause flags |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 mode, 1 key |
| wr_data | input | 8 | Write data |
| sys_tick | input | 1 | System-clock count enable |
| slow_tick | input | 1 | Slow-oscillator count enable |
| slow_forced | input | 1 | Option strap: slow tick always used |
| rst_req | output | 1 | One-cycle internal reset request |
| cause_overflow | output | 1 | Sticky: a request came from overflow |
| cause_access | output | 1 | Sticky: a request came from an illegal write |
| mode_rd | output | 8 | Current mode register value |

## Verification
The bench builds the block with SYS_BASE = 3 and SLOW_BASE = 1, which shrinks every period to between 2 and 1024 ticks. At these sizes each source and code corner can be timed to the exact tick: the reset-default period, the longest system period, the shortest one, the strap override, and the stopped case. The write-once, key and stray-address cases do not depend on the period, so they are checked with the same build.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int          CODE_W     = 3;
    localparam int          NUM_CODES  = 1 << CODE_W;
    localparam logic [7:0]  KEY_BYTE   = 8'hAC;
    localparam logic [2:0]  MODE_FIXED = 3'b011;
    localparam logic [7:0]  MODE_RESET = {MODE_FIXED, 2'b00, 3'b111};
    localparam int          ADDR_MODE  = 0;
    localparam int          ADDR_KEY   = 1;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'd0,
        SRC_SYS  = 2'd1,
        SRC_STOP = 2'd2
    } wdt_src_e;

    typedef struct packed {
        logic [7:0] mode;
        logic       lock;
        logic       req;
    } wdt_ctl_t;

    typedef struct packed {
        logic ovf;
        logic acc;
    } wdt_cause_t;

endpackage

// File: rtl/wdt_access.sv
module wdt_access
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              locked,
    input  logic              first_stopped,
    output logic              mode_load,
    output logic              key_ok,
    output logic              bad_access
);

    logic hit_mode;
    logic hit_key;

    always_comb begin
        hit_mode   = wr_en && (wr_addr == ADDR_W'(ADDR_MODE));
        hit_key    = wr_en && (wr_addr == ADDR_W'(ADDR_KEY));
        mode_load  = 1'b0;
        key_ok     = 1'b0;
        bad_access = 1'b0;
        if (hit_mode) begin
            if (!locked) begin
                mode_load = 1'b1;
            end else if (!first_stopped) begin
                bad_access = 1'b1;
            end
        end
        if (hit_key) begin
            if (wr_data == KEY_BYTE) begin
                key_ok = 1'b1;
            end else begin
                bad_access = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdt_period_dec.sv
module wdt_period_dec
    import wdt_pkg::*;
#(
    parameter int SYS_BASE  = 13,
    parameter int SLOW_BASE = 11,
    parameter int CNT_W     = 20
) (
    input  logic [4:0]       mode_lo,
    input  logic             slow_forced,
    input  logic             sys_tick,
    input  logic             slow_tick,
    output logic             running,
    output logic             tick,
    output logic [CNT_W-1:0] term
);

    logic [CNT_W-1:0] sys_terms  [NUM_CODES];
    logic [CNT_W-1:0] slow_terms [NUM_CODES];
    wdt_src_e         src;
    logic [CODE_W-1:0] code;

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_terms
        localparam int SYS_E  = SYS_BASE + g;
        localparam int SLOW_E = SLOW_BASE + g;
        assign sys_terms[g]  = CNT_W'((64'd1 << SYS_E) - 64'd1);
        assign slow_terms[g] = CNT_W'((64'd1 << SLOW_E) - 64'd1);
    end

    always_comb begin
        code = mode_lo[CODE_W-1:0];
        if (slow_forced) begin
            src = SRC_SLOW;
        end else if (mode_lo[4]) begin
            src = SRC_STOP;
        end else if (mode_lo[3]) begin
            src = SRC_SYS;
        end else begin
            src = SRC_SLOW;
        end
        case (src)
            SRC_SYS: begin
                running = 1'b1;
                tick    = sys_tick;
                term    = sys_terms[code];
            end
            SRC_SLOW: begin
                running = 1'b1;
                tick    = slow_tick;
                term    = slow_terms[code];
            end
            default: begin
                running = 1'b0;
                tick    = 1'b0;
                term    = slow_terms[code];
            end
        endcase
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             running,
    input  logic             tick,
    input  logic [CNT_W-1:0] term,
    output logic             fire
);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        fire  = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (running && tick) begin
            if (cnt_q == term) begin
                cnt_d = '0;
                fire  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int SYS_BASE  = 13,
    parameter int SLOW_BASE = 11,
    parameter int ADDR_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              sys_tick,
    input  logic              slow_tick,
    input  logic              slow_forced,
    output logic              rst_req,
    output logic              cause_overflow,
    output logic              cause_access,
    output logic [7:0]        mode_rd
);

    localparam int BIG_BASE = (SYS_BASE > SLOW_BASE) ? SYS_BASE : SLOW_BASE;
    localparam int CNT_W    = BIG_BASE + NUM_CODES - 1;

    wdt_ctl_t         ctl_d, ctl_q;
    wdt_cause_t       cause_d, cause_q;
    logic             mode_load, key_ok, bad_access;
    logic             running, tick, fire;
    logic [CNT_W-1:0] term;
    logic             lock_q;

    assign lock_q = ctl_q.lock;

    wdt_access #(.ADDR_W(ADDR_W)) u_access (
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .locked        (ctl_q.lock),
        .first_stopped (ctl_q.mode[4]),
        .mode_load     (mode_load),
        .key_ok        (key_ok),
        .bad_access    (bad_access)
    );

    wdt_period_dec #(
        .SYS_BASE  (SYS_BASE),
        .SLOW_BASE (SLOW_BASE),
        .CNT_W     (CNT_W)
    ) u_dec (
        .mode_lo     (ctl_q.mode[4:0]),
        .slow_forced (slow_forced),
        .sys_tick    (sys_tick),
        .slow_tick   (slow_tick),
        .running     (running),
        .tick        (tick),
        .term        (term)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (key_ok | mode_load),
        .running (running),
        .tick    (tick),
        .term    (term),
        .fire    (fire)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.req = fire | bad_access;
        if (mode_load) begin
            ctl_d.mode = {MODE_FIXED, wr_data[4:0]};
            ctl_d.lock = 1'b1;
        end
        cause_d = cause_q;
        if (fire) begin
            cause_d.ovf = 1'b1;
        end
        if (bad_access) begin
            cause_d.acc = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{mode: MODE_RESET, lock: 1'b0, req: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cause_q <= '0;
        end else if (rst_n) begin
            cause_q <= cause_d;
        end
    end

    assign rst_req        = ctl_q.req;
    assign cause_overflow = cause_q.ovf;
    assign cause_access   = cause_q.acc;
    assign mode_rd        = ctl_q.mode;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              slow_forced,
    input logic              rst_req,
    input logic              cause_access,
    input logic [7:0]        mode_rd,
    input logic              lock
);

    logic key_wr;
    logic mode_wr;
    assign key_wr  = wr_en && (wr_addr == ADDR_W'(ADDR_KEY));
    assign mode_wr = wr_en && (wr_addr == ADDR_W'(ADDR_MODE));

    p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rd[7:5] == MODE_FIXED);

    p_key_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wr_data == KEY_BYTE) |=> !rst_req);

    p_bad_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wr_data != KEY_BYTE) |=> (rst_req && cause_access));

    p_relock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && lock && !mode_rd[4]) |=> (rst_req && $stable(mode_rd)));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd[4] && !slow_forced && !wr_en) |=> !rst_req);

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !wr_en) |=> !rst_req);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!por_n)
        cause_access |=> cause_access);

endmodule

bind keyed_wdt wdt_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_n        (por_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .slow_forced  (slow_forced),
    .rst_req      (rst_req),
    .cause_access (cause_access),
    .mode_rd      (mode_rd),
    .lock         (lock_q)
);

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;

    localparam int SB = 3;
    localparam int LB = 1;
    localparam int AW = 2;
    localparam int NONE_WIN = 1100;

    // {mode[7:0], strap, drive_sys, drive_slow, expected ticks (0 = none)}
    localparam logic [22:0] VEC [10] = '{
        {8'h6F, 1'b0, 1'b1, 1'b0, 12'd1024},  // R1 sys code 7
        {8'h68, 1'b0, 1'b1, 1'b0, 12'd8},     // R1 sys code 0
        {8'h6B, 1'b0, 1'b1, 1'b0, 12'd64},    // R1 sys code 3
        {8'h62, 1'b0, 1'b0, 1'b1, 12'd8},     // R1 slow code 2
        {8'h67, 1'b0, 1'b0, 1'b1, 12'd256},   // R1 slow code 7
        {8'h6D, 1'b1, 1'b0, 1'b1, 12'd64},    // R7 strap over sys
        {8'h6D, 1'b1, 1'b1, 1'b0, 12'd0},     // R7 sys tick ignored
        {8'h77, 1'b0, 1'b1, 1'b1, 12'd0},     // R8 stopped
        {8'h77, 1'b1, 1'b0, 1'b1, 12'd256},   // R7 strap over stop
        {8'h69, 1'b0, 1'b0, 1'b1, 12'd0}      // R1 wrong tick
    };

    logic          clk = 1'b0;
    logic          rst_n, por_n, wr_en, sys_tick, slow_tick, slow_forced;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data, mode_rd;
    logic          rst_req, cause_overflow, cause_access;
    int            n_run = 0;
    int            n_fail = 0;

    always #4 clk = ~clk;

    keyed_wdt #(.SYS_BASE(SB), .SLOW_BASE(LB), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sys_tick(sys_tick),
        .slow_tick(slow_tick), .slow_forced(slow_forced), .rst_req(rst_req),
        .cause_overflow(cause_overflow), .cause_access(cause_access),
        .mode_rd(mode_rd)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_reset(input bit with_por);
        @(negedge clk);
        rst_n = 1'b0; if (with_por) por_n = 1'b0;
        wr_en = 1'b0; sys_tick = 1'b0; slow_tick = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(input int limit, output int n);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (rst_req) begin n = i; return; end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; por_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        sys_tick = 1'b0; slow_tick = 1'b0; slow_forced = 1'b0;
        hold_reset(1'b1);

        // R3 reset state and default run
        chk("R3 mode", mode_rd, 8'h67);
        chk("R3 req", rst_req, 0);
        chk("R10 flags clear", {cause_overflow, cause_access}, 0);
        slow_tick = 1'b1;
        measure(NONE_WIN, n);
        chk("R3 default period", n, 256);
        chk("R10 overflow flag", {cause_overflow, cause_access}, 2'b10);
        @(negedge clk);
        chk("R9 one-cycle pulse", rst_req, 0);

        // Vector table: source and period decoding
        for (int v = 0; v < 10; v++) begin
            hold_reset(1'b1);
            slow_forced = VEC[v][14];
            sys_tick    = VEC[v][13];
            slow_tick   = VEC[v][12];
            wr(AW'(0), VEC[v][22:15]);
            measure(NONE_WIN, n);
            chk($sformatf("R1 R7 R8 vector %0d period", v), n, int'(VEC[v][11:0]));
            if (VEC[v][11:0] != 0) begin
                chk("R10 overflow cause", {cause_overflow, cause_access}, 2'b10);
                @(negedge clk);
                chk("R9 pulse ends", rst_req, 0);
            end
        end
        slow_forced = 1'b0;

        // R4 key clear
        hold_reset(1'b1);
        slow_tick = 1'b1;
        repeat (200) @(negedge clk);
        wr(AW'(1), 8'hAC);
        chk("R4 no request on key", rst_req, 0);
        measure(NONE_WIN, n);
        chk("R4 full period after key", n, 256);

        // R9 accepted mode write clears the count
        hold_reset(1'b1);
        slow_tick = 1'b1;
        repeat (100) @(negedge clk);
        wr(AW'(0), 8'h67);
        measure(NONE_WIN, n);
        chk("R9 mode write clears count", n, 256);

        // R5 bad key, R10 stickiness
        hold_reset(1'b1);
        wr(AW'(1), 8'h55);
        chk("R5 request on bad key", rst_req, 1);
        chk("R5 access cause", {cause_overflow, cause_access}, 2'b01);
        @(negedge clk);
        chk("R9 pulse ends after bad key", rst_req, 0);
        hold_reset(1'b0);
        chk("R10 flag survives rst_n", cause_access, 1);
        hold_reset(1'b1);
        chk("R10 flag cleared by por_n", cause_access, 0);

        // R6 second write
        wr(AW'(0), 8'h6F);
        chk("R6 first write accepted", rst_req, 0);
        wr(AW'(0), 8'h68);
        chk("R6 second write requests", rst_req, 1);
        chk("R6 second write cause", cause_access, 1);
        chk("R6 mode unchanged", mode_rd, 8'h6F);

        // R6 stopped first write exempts later writes
        hold_reset(1'b1);
        wr(AW'(0), 8'h77);
        wr(AW'(0), 8'h6F);
        chk("R6 stop exemption no request", rst_req, 0);
        chk("R6 stop exemption mode kept", mode_rd, 8'h77);
        chk("R6 stop exemption flags", {cause_overflow, cause_access}, 0);

        // R2 fixed upper bits
        hold_reset(1'b1);
        wr(AW'(0), 8'h8A);
        chk("R2 upper bits forced", mode_rd, 8'h6A);

        // R11 undefined addresses
        hold_reset(1'b1);
        wr(AW'(2), 8'h00);
        chk("R11 addr 2 no request", rst_req, 0);
        chk("R11 addr 2 mode kept", mode_rd, 8'h67);
        wr(AW'(3), 8'h12);
        chk("R11 addr 3 no request", rst_req, 0);
        wr(AW'(0), 8'h6C);
        chk("R11 lock untouched", rst_req, 0);
        chk("R11 mode then loads", mode_rd, 8'h6C);
        chk("R11 flags", {cause_overflow, cause_access}, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule